// File: doc/BRIEF.md
# Store-and-Forward Transmit Stream Adapter

This block joins a packet source that must deliver each packet as one unbroken burst to a transmit port that may pull its ready signal low at any beat, including in the middle of a packet. Beats arrive on a 64-bit AXI4-Stream slave and leave on a 64-bit AXI4-Stream master. Each beat carries data, byte keep, last and a user (error) flag. All four travel together through one first-word-fall-through FIFO entry.

The input side is admitted one packet at a time. Ready is raised only at a packet boundary, and only when the FIFO can absorb a whole maximum-size frame. Once raised, it stays high until the last beat, so the source never sees a stall inside a packet. The output side opens a packet once a few words are queued. It keeps valid high until the last beat is taken and holds every output field steady while the sink stalls. After each packet, both sides drop their handshake for at least one cycle and check the occupancy again. Both sides share one clock.

Top module: `sfa_tx_adapter`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, `s_axis_tready` and `m_axis_tvalid` are low and the FIFO is empty.
- R2: Beats leave in the order they were accepted, with data, keep, last and user unchanged. Each FIFO entry packs {user, last, keep[7:0], data[63:0]} into 74 bits.
- R3: `s_axis_tready` rises only from low, and only when the registered occupancy is at most ADMIT_MAX entries (768 by default).
- R4: On the cycle after a beat with last set is accepted, `s_axis_tready` is low.
- R5: With occupancy at or below ADMIT_MAX, `s_axis_tready` returns high exactly one cycle after it dropped at the end of a packet.
- R6: `m_axis_tvalid` rises only from low, and only when occupancy is at least START_MIN (4 by default, i.e. count bits above bit 1 are non-zero). For an empty FIFO fed one beat per cycle, it rises five cycles after the first input handshake.
- R7: While `m_axis_tvalid` is high and `m_axis_tready` is low, `m_axis_tdata`, `m_axis_tkeep`, `m_axis_tlast` and `m_axis_tuser` hold their values on the next cycle.
- R8: On the cycle after an output beat with last set is accepted, `m_axis_tvalid` is low.
- R9: Once `m_axis_tvalid` is high, it stays high on every cycle until a beat with last set is accepted.
- R10: The FIFO is never written when full and never read when empty.
- R11: Once `s_axis_tready` is high, it stays high on every cycle until a beat with last set is accepted.
- R12: While occupancy exceeds ADMIT_MAX, `s_axis_tready` stays low. It rises again once the output drains the FIFO to ADMIT_MAX or below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both streams |
| rst | input | 1 | Synchronous reset, active high |
| s_axis_tdata | input | 64 | Input beat data |
| s_axis_tkeep | input | 8 | Input byte keep |
| s_axis_tlast | input | 1 | Input end of packet |
| s_axis_tuser | input | 1 | Input error flag |
| s_axis_tvalid | input | 1 | Input beat valid |
| s_axis_tready | output | 1 | Input accept, granted per packet |
| m_axis_tdata | output | 64 | Output beat data |
| m_axis_tkeep | output | 8 | Output byte keep |
| m_axis_tlast | output | 1 | Output end of packet |
| m_axis_tuser | output | 1 | Output error flag |
| m_axis_tvalid | output | 1 | Output beat valid |
| m_axis_tready | input | 1 | Output sink ready |

## Verification
The hardest case to reach from the ports is the admission gate staying shut. That needs the FIFO to hold more than a threshold's worth of data while a packet boundary is pending. The bench uses a shrunken FIFO with a low threshold and holds the output ready low. It then pushes two packets so the first is admitted below the threshold and the second takes occupancy above it. It watches input ready stay low for a long window, and then lets the output drain until ready returns. Start latency and the one-cycle input gap are measured against an empty FIFO with an always-ready sink. Hold and gap-free output behaviour are checked under a pseudo-random output stall pattern.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
   localparam int SFA_DATA_W      = 64;
   localparam int SFA_DEPTH       = 2048;
   localparam int SFA_ADMIT_MAX   = 768;
   localparam int SFA_START_MIN   = 4;
   localparam int SFA_MAX_PKT_WDS = 1127;

   function automatic int occ_width(input int depth);
      return $clog2(depth) + 1;
   endfunction
endpackage

// File: rtl/sfa_fifo.sv
module sfa_fifo #(
   parameter int W     = 74,
   parameter int DEPTH = 2048,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = sfa_pkg::occ_width(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             rd_en,
   output logic [W-1:0]     rd_data,
   output logic [CNT_W-1:0] occ
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
         occ <= occ + CNT_W'(wr_en) - CNT_W'(rd_en);
      end
   end

   // fall-through head
   assign rd_data = mem[rd_ptr];

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !rd_en) |-> (occ != FULL));
   p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
      rd_en |-> (occ != '0));
endmodule

// File: rtl/sfa_in_gate.sv
module sfa_in_gate #(
   parameter int W         = 74,
   parameter int CNT_W     = 12,
   parameter int ADMIT_MAX = 768
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             s_vld,
   input  logic             s_last,
   input  logic [W-1:0]     s_beat,
   input  logic [CNT_W-1:0] occ,
   output logic             s_rdy,
   output logic             wr_en,
   output logic [W-1:0]     wr_data
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(ADMIT_MAX);
   localparam bit POW2_GATE = (((ADMIT_MAX + 1) & ADMIT_MAX) == 0);

   logic room;
   logic take;

   generate
      if (POW2_GATE) begin : g_msb_gate
         // threshold of form 2^k-1: only the bits above k need to be zero
         assign room = ((occ >> $clog2(ADMIT_MAX + 1)) == '0);
      end else begin : g_cmp_gate
         assign room = (occ <= LIM);
      end
   endgenerate

   assign take = s_vld && s_rdy;

   always_ff @(posedge clk) begin
      if (rst) begin
         s_rdy <= 1'b0;
         wr_en <= 1'b0;
      end else begin
         wr_en <= take;
         if (take && s_last)    s_rdy <= 1'b0;
         else if (!s_rdy && room) s_rdy <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (take) wr_data <= s_beat;
   end

   p_admit_room_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(s_rdy) |-> ($past(occ) <= LIM));
   p_drop_after_last_r4: assert property (@(posedge clk) disable iff (rst)
      (s_vld && s_rdy && s_last) |=> !s_rdy);
   p_steady_in_pkt_r11: assert property (@(posedge clk) disable iff (rst)
      (s_rdy && !(s_vld && s_last)) |=> s_rdy);
endmodule

// File: rtl/sfa_out_gate.sv
module sfa_out_gate #(
   parameter int CNT_W     = 12,
   parameter int START_MIN = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] occ,
   input  logic             head_last,
   input  logic             m_rdy,
   output logic             m_vld,
   output logic             rd_en
);
   localparam logic [CNT_W-1:0] START_LIM = CNT_W'(START_MIN);

   assign rd_en = m_vld && m_rdy;

   always_ff @(posedge clk) begin
      if (rst) begin
         m_vld <= 1'b0;
      end else if (rd_en && head_last) begin
         m_vld <= 1'b0;
      end else if (!m_vld && (occ >= START_LIM)) begin
         m_vld <= 1'b1;
      end
   end

   p_start_fill_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(m_vld) |-> ($past(occ) >= START_LIM));
   p_drop_after_last_r8: assert property (@(posedge clk) disable iff (rst)
      (m_vld && m_rdy && head_last) |=> !m_vld);
   p_gap_free_r9: assert property (@(posedge clk) disable iff (rst)
      (m_vld && !(m_rdy && head_last)) |=> m_vld);
endmodule

// File: rtl/sfa_tx_adapter.sv
module sfa_tx_adapter #(
   parameter int DATA_W      = sfa_pkg::SFA_DATA_W,
   parameter int DEPTH       = sfa_pkg::SFA_DEPTH,
   parameter int ADMIT_MAX   = sfa_pkg::SFA_ADMIT_MAX,
   parameter int START_MIN   = sfa_pkg::SFA_START_MIN,
   parameter int MAX_PKT_WDS = sfa_pkg::SFA_MAX_PKT_WDS,
   localparam int KEEP_W  = DATA_W / 8,
   localparam int ENTRY_W = DATA_W + KEEP_W + 2,
   localparam int CNT_W   = sfa_pkg::occ_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] s_axis_tdata,
   input  logic [KEEP_W-1:0] s_axis_tkeep,
   input  logic              s_axis_tlast,
   input  logic              s_axis_tuser,
   input  logic              s_axis_tvalid,
   output logic              s_axis_tready,
   output logic [DATA_W-1:0] m_axis_tdata,
   output logic [KEEP_W-1:0] m_axis_tkeep,
   output logic              m_axis_tlast,
   output logic              m_axis_tuser,
   output logic              m_axis_tvalid,
   input  logic              m_axis_tready
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if (ADMIT_MAX + 1 + MAX_PKT_WDS > DEPTH) begin : g_bad_admit
         $error("ADMIT_MAX leaves no room for a maximum packet");
      end
      if (START_MIN < 1 || START_MIN > DEPTH) begin : g_bad_start
         $error("START_MIN out of range");
      end
   endgenerate

   logic [ENTRY_W-1:0] s_beat, wr_data, head;
   logic [CNT_W-1:0]   occ;
   logic               wr_en, rd_en;

   assign s_beat = {s_axis_tuser, s_axis_tlast, s_axis_tkeep, s_axis_tdata};

   sfa_in_gate #(.W(ENTRY_W), .CNT_W(CNT_W), .ADMIT_MAX(ADMIT_MAX)) i_in_gate (
      .clk     (clk),
      .rst     (rst),
      .s_vld   (s_axis_tvalid),
      .s_last  (s_axis_tlast),
      .s_beat  (s_beat),
      .occ     (occ),
      .s_rdy   (s_axis_tready),
      .wr_en   (wr_en),
      .wr_data (wr_data)
   );

   sfa_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (head),
      .occ     (occ)
   );

   assign {m_axis_tuser, m_axis_tlast, m_axis_tkeep, m_axis_tdata} = head;

   sfa_out_gate #(.CNT_W(CNT_W), .START_MIN(START_MIN)) i_out_gate (
      .clk       (clk),
      .rst       (rst),
      .occ       (occ),
      .head_last (m_axis_tlast),
      .m_rdy     (m_axis_tready),
      .m_vld     (m_axis_tvalid),
      .rd_en     (rd_en)
   );

   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (!s_axis_tready && !m_axis_tvalid && (occ == '0)));
   p_hold_stalled_r7: assert property (@(posedge clk) disable iff (rst)
      (m_axis_tvalid && !m_axis_tready) |=>
         ($stable(m_axis_tdata) && $stable(m_axis_tkeep) &&
          $stable(m_axis_tlast) && $stable(m_axis_tuser)));
endmodule

// File: tb/test_sfa_tx_adapter.sv
module test_sfa_tx_adapter;
   localparam int DW = 64;
   localparam int KW = 8;
   localparam int DEPTH = 64;
   localparam int ADMIT = 24;
   localparam int START = 4;
   localparam int MAXW  = 32;

   typedef struct packed {
      logic [DW-1:0] data;
      logic [KW-1:0] keep;
      logic          last;
      logic          user;
   } beat_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [DW-1:0] s_tdata = '0;
   logic [KW-1:0] s_tkeep = '0;
   logic          s_tlast = 1'b0, s_tuser = 1'b0, s_tvalid = 1'b0;
   logic          s_tready;
   logic [DW-1:0] m_tdata;
   logic [KW-1:0] m_tkeep;
   logic          m_tlast, m_tuser, m_tvalid;
   logic          m_tready = 1'b0;

   int total = 0, bad = 0;
   int cyc = 0;
   int hs0_cyc = 0, rise_cyc = 0;
   int rdy_mode = 0;
   bit done = 1'b0;
   beat_t expq[$];

   always #2 clk = ~clk;   // 250 MHz
   always @(posedge clk) cyc <= cyc + 1;

   sfa_tx_adapter #(.DATA_W(DW), .DEPTH(DEPTH), .ADMIT_MAX(ADMIT),
                    .START_MIN(START), .MAX_PKT_WDS(MAXW)) i_sfa_tx_adapter (
      .clk(clk), .rst(rst),
      .s_axis_tdata(s_tdata), .s_axis_tkeep(s_tkeep), .s_axis_tlast(s_tlast),
      .s_axis_tuser(s_tuser), .s_axis_tvalid(s_tvalid), .s_axis_tready(s_tready),
      .m_axis_tdata(m_tdata), .m_axis_tkeep(m_tkeep), .m_axis_tlast(m_tlast),
      .m_axis_tuser(m_tuser), .m_axis_tvalid(m_tvalid), .m_axis_tready(m_tready));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // output ready pattern: 0 = always, 1 = pseudo-random, 2 = held low
   initial begin
      logic [15:0] lfsr = 16'hACE1;
      forever begin
         @(posedge clk); #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (rdy_mode)
            0: m_tready = 1'b1;
            1: m_tready = lfsr[0] | lfsr[3];
            default: m_tready = 1'b0;
         endcase
      end
   end

   // driver: one packet, gap-free, after ready is granted
   task automatic send_pkt(input int len, input int pid, input bit usr);
      beat_t b;
      @(posedge clk); #1;
      while (!s_tready) begin @(posedge clk); #1; end
      for (int i = 0; i < len; i++) begin
         b.data = {16'(pid), 16'(i), 32'hC0DE_0000 ^ 32'(pid * 977 + i)};
         b.last = (i == len - 1);
         b.keep = b.last ? (8'hFF >> (len % 8)) : 8'hFF;
         b.user = usr;
         s_tdata = b.data; s_tkeep = b.keep; s_tlast = b.last; s_tuser = b.user;
         s_tvalid = 1'b1;
         expq.push_back(b);
         chk(s_tready == 1'b1, "R11", "input ready inside packet", 64'(s_tready), 1);
         @(posedge clk); #1;
         if (i == 0) hs0_cyc = cyc;
      end
      s_tvalid = 1'b0; s_tlast = 1'b0;
      chk(s_tready == 1'b0, "R4", "input ready after last", 64'(s_tready), 0);
   endtask

   // monitor / scoreboard
   initial begin
      logic pv = 0, pr = 0, pl = 0, pu = 0;
      logic [DW-1:0] pd = '0;
      logic [KW-1:0] pk = '0;
      beat_t e;
      forever begin
         @(negedge clk);
         if (!rst) begin
            if (pv && !pr) begin
               chk(m_tdata == pd && m_tkeep == pk && m_tlast == pl && m_tuser == pu,
                   "R7", "held data", 64'(m_tdata), 64'(pd));
               chk(m_tvalid == 1'b1, "R9", "valid during stall", 64'(m_tvalid), 1);
            end
            if (pv && pr && pl)
               chk(m_tvalid == 1'b0, "R8", "valid after last", 64'(m_tvalid), 0);
            if (pv && pr && !pl)
               chk(m_tvalid == 1'b1, "R9", "valid inside packet", 64'(m_tvalid), 1);
            if (m_tvalid && !pv) rise_cyc = cyc;
            if (m_tvalid && m_tready) begin
               if (expq.size() == 0) begin
                  chk(1'b0, "R2", "unexpected beat", 64'(m_tdata), 0);
               end else begin
                  e = expq.pop_front();
                  chk(m_tdata == e.data, "R2", "data", 64'(m_tdata), 64'(e.data));
                  chk(m_tkeep == e.keep && m_tlast == e.last && m_tuser == e.user,
                      "R2", "keep/last/user", 64'({m_tkeep, m_tlast, m_tuser}),
                      64'({e.keep, e.last, e.user}));
               end
            end
         end
         pv = m_tvalid; pr = m_tready; pl = m_tlast; pu = m_tuser;
         pd = m_tdata; pk = m_tkeep;
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         if (cyc > 60000) begin
            chk(1'b0, "WDOG", "watchdog expired", 64'(cyc), 0);
            finish_run();
         end
      end
   end

   task automatic wait_drain();
      while (expq.size() != 0) @(posedge clk);
      repeat (4) @(posedge clk);
   endtask

   initial begin
      int seed = 7;
      // R1 reset state
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(s_tready == 1'b0 && m_tvalid == 1'b0, "R1", "outputs in reset",
          64'({s_tready, m_tvalid}), 0);
      @(posedge clk); #1; rst = 1'b0;
      @(negedge clk);
      chk(s_tready == 1'b0 && m_tvalid == 1'b0, "R1", "first cycle after reset",
          64'({s_tready, m_tvalid}), 0);
      repeat (5) @(negedge clk);
      chk(m_tvalid == 1'b0, "R1", "empty FIFO stays idle", 64'(m_tvalid), 0);

      // R6 start latency, R5 one-cycle input gap
      rdy_mode = 0;
      send_pkt(8, 1, 1'b0);
      @(posedge clk); #1;
      chk(s_tready == 1'b1, "R5", "ready back after one cycle", 64'(s_tready), 1);
      wait_drain();
      chk(rise_cyc - hs0_cyc == 5, "R6", "output start latency",
          64'(rise_cyc - hs0_cyc), 5);

      // R2 back-to-back packets of varied length, max size included
      send_pkt(4, 2, 1'b1);
      send_pkt(5, 3, 1'b0);
      send_pkt(13, 4, 1'b1);
      send_pkt(MAXW, 5, 1'b0);
      wait_drain();

      // R7/R9 under random output stalls
      rdy_mode = 1;
      for (int p = 0; p < 12; p++) begin
         seed = (seed * 1103 + 12345) % 10007;
         send_pkt(4 + (seed % (MAXW - 3)), 10 + p, seed[0]);
      end
      wait_drain();

      // R12 admission blocked above threshold
      rdy_mode = 2;
      repeat (3) @(posedge clk);
      send_pkt(20, 40, 1'b0);
      send_pkt(20, 41, 1'b1);
      begin
         int hi = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (s_tready) hi++;
         end
         chk(hi == 0, "R12", "ready high cycles while above threshold", 64'(hi), 0);
      end
      rdy_mode = 1;
      wait_drain();
      @(negedge clk);
      chk(s_tready == 1'b1, "R12", "ready after drain", 64'(s_tready), 1);

      rdy_mode = 0;
      send_pkt(6, 50, 1'b1);
      wait_drain();
      finish_run();
   end
endmodule